// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind a bit-level I2C receiver and decides, byte by byte, whether the device is being addressed as a slave. The receiver reports each START (first or repeated) and each STOP, and hands over each received byte. After every address byte it judges, the block returns an ACK or NACK decision. When addressing succeeds, it raises a slave-mode flag and a sticky interrupt flag. Once slave mode is entered, later bytes belong to the data phase, which another block handles.

Both 7-bit and 10-bit addressing are recognized. A 7-bit address is matched in one byte. A 10-bit address needs two bytes. The first byte carries a fixed five-bit header and the two top address bits; the block accepts it without an interrupt. Slave mode and the interrupt follow only when the second byte also matches. Software programs the own address, the extended address and the control flags through an 8-bit register port. A write-only reset register aborts recognition at any time.

Top module: `i2c_addr_recog`

## Requirements
- R1: After a hardware reset, registers 0, 1 and 2 read 00h, and ack_vld, slave_mode and irq are 0.
- R2: After a START, a byte whose bits [7:1] equal own-address register bits [7:1] gives ack_vld=1 with ack=1 on the cycle after the byte. On that same cycle slave_mode and irq become 1. Bit 0 of the byte (the direction bit) is not compared.
- R3: A 7-bit address mismatch gives ack_vld=1 with ack=0 and returns to idle. Bytes that arrive with no START since the last decision produce no ack_vld.
- R4: After a START, a byte of the form 11110xxb whose xx equals own-address bits [2:1] gives ack=1. It leaves slave_mode and irq unchanged.
- R5: In the second 10-bit stage, a byte equal to the extended address register gives ack=1 and sets slave_mode and irq.
- R6: A mismatch in either 10-bit stage gives ack=0 and returns to idle, with slave_mode 0.
- R7: A START during the 10-bit second stage restarts recognition, and the next byte is judged as a first address byte.
- R8: irq stays at 1 until a write to register 2 with bit 0 = 0. A write to register 2 with bit 0 = 1 leaves it set.
- R9: A write of any value to register 3 returns the block to idle. It clears slave_mode, irq, and the start-request and stop-request bits. The address registers keep their contents.
- R10: START or STOP leaves slave mode. Bytes received in slave mode produce no ack_vld.
- R11: The register map is: 0 own address, 1 extended address, 2 control (bit 2 stop request, bit 1 start request, bit 0 irq), 3 software reset (write-only, reads 00h). A START takes priority over a byte in the same cycle, and a software reset takes priority over everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| rx_start | input | 1 | START or repeated START seen (one-cycle pulse) |
| rx_stop | input | 1 | STOP seen (one-cycle pulse) |
| rx_byte_vld | input | 1 | Received byte valid (one-cycle pulse) |
| rx_byte | input | 8 | Received byte, first bus bit in bit 7 |
| ack_vld | output | 1 | An ACK/NACK decision is presented |
| ack | output | 1 | 1 = ACK, 0 = NACK, valid with ack_vld |
| slave_mode | output | 1 | Device has been addressed as a slave |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The recognizer is driven with several kinds of address byte, each chosen to separate one decision from the others:
- A matching 7-bit address with the direction bit set shows that bit 0 is ignored.
- An address one step away shows that the compare is exact.
- A 10-bit header with wrong top bits, and a correct header followed by an extended byte off by one, show that each stage checks on its own.
- Bytes sent with no START, and bytes sent inside slave mode, separate "ignored" from "NACK".
- A repeated START between the two 10-bit stages, followed first by a valid 7-bit address and then by the extended byte alone, shows that recognition truly restarts.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int BYTE_W  = 8;
  localparam int REG_AW  = 2;
  localparam int HDR_W   = 5;
  localparam logic [HDR_W-1:0] TEN_HDR = 5'b11110;

  localparam logic [REG_AW-1:0] RA_OWN  = 2'd0;
  localparam logic [REG_AW-1:0] RA_EXT  = 2'd1;
  localparam logic [REG_AW-1:0] RA_CTL  = 2'd2;
  localparam logic [REG_AW-1:0] RA_SRST = 2'd3;

  localparam int CTL_IRQ = 0;
  localparam int CTL_STA = 1;
  localparam int CTL_STP = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR1 = 2'd1,
    ST_ADDR2 = 2'd2,
    ST_SLAVE = 2'd3
  } rec_state_e;
endpackage

// File: rtl/i2c_addr_regs.sv
module i2c_addr_regs
  import i2c_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              irq_set,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] own_addr,
  output logic [BYTE_W-1:0] ext_addr,
  output logic              irq,
  output logic              srst
);
  logic [BYTE_W-1:0] own_q, own_d, ext_q, ext_d;
  logic irq_q, irq_d, sta_q, sta_d, stp_q, stp_d;
  logic wr_own, wr_ext, wr_ctl;

  assign wr_own = wr_en && (addr == RA_OWN);
  assign wr_ext = wr_en && (addr == RA_EXT);
  assign wr_ctl = wr_en && (addr == RA_CTL);
  assign srst   = wr_en && (addr == RA_SRST);

  always_comb begin
    own_d = own_q;
    ext_d = ext_q;
    if (wr_own) own_d = wdata;
    if (wr_ext) ext_d = wdata;
  end

  always_comb begin
    irq_d = irq_q;
    sta_d = sta_q;
    stp_d = stp_q;
    if (srst) begin
      irq_d = 1'b0;
      sta_d = 1'b0;
      stp_d = 1'b0;
    end else begin
      if (wr_ctl) begin
        sta_d = wdata[CTL_STA];
        stp_d = wdata[CTL_STP];
        if (!wdata[CTL_IRQ]) irq_d = 1'b0;
      end
      if (irq_set) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
      ext_q <= '0;
      irq_q <= 1'b0;
      sta_q <= 1'b0;
      stp_q <= 1'b0;
    end else begin
      own_q <= own_d;
      ext_q <= ext_d;
      irq_q <= irq_d;
      sta_q <= sta_d;
      stp_q <= stp_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      RA_OWN:  rdata = own_q;
      RA_EXT:  rdata = ext_q;
      RA_CTL: begin
        rdata[CTL_IRQ] = irq_q;
        rdata[CTL_STA] = sta_q;
        rdata[CTL_STP] = stp_q;
      end
      default: rdata = '0;
    endcase
  end

  assign own_addr = own_q;
  assign ext_addr = ext_q;
  assign irq      = irq_q;

  // R9: the address registers survive a software reset
  p_srst_keeps_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (own_q == $past(own_q)) && (ext_q == $past(ext_q)));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_pkg::*;
#(
  parameter bit TEN_BIT_EN = 1'b1
) (
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] ext_addr,
  output logic              ten_hdr,
  output logic              hdr_hit,
  output logic              seven_hit,
  output logic              low_hit
);
  localparam int HI_W = BYTE_W - HDR_W - 1;

  assign seven_hit = (rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-1:1]);

  generate
    if (TEN_BIT_EN) begin : g_ten
      assign ten_hdr = (rx_byte[BYTE_W-1:BYTE_W-HDR_W] == TEN_HDR);
      assign hdr_hit = ten_hdr && (rx_byte[HI_W:1] == own_addr[HI_W:1]);
      assign low_hit = (rx_byte == ext_addr);
    end else begin : g_seven
      assign ten_hdr = 1'b0;
      assign hdr_hit = 1'b0;
      assign low_hit = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
  import i2c_addr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic rx_start,
  input  logic rx_stop,
  input  logic rx_byte_vld,
  input  logic ten_hdr,
  input  logic hdr_hit,
  input  logic seven_hit,
  input  logic low_hit,
  output logic ack_vld,
  output logic ack,
  output logic slave_mode,
  output logic irq_set
);
  rec_state_e state_q, state_d;
  logic ack_vld_q, ack_vld_d, ack_q, ack_d;

  always_comb begin
    state_d   = state_q;
    ack_vld_d = 1'b0;
    ack_d     = 1'b0;
    irq_set   = 1'b0;
    if (srst) begin
      state_d = ST_IDLE;
    end else if (rx_start) begin
      state_d = ST_ADDR1;
    end else if (rx_stop) begin
      state_d = ST_IDLE;
    end else if (rx_byte_vld) begin
      unique case (state_q)
        ST_ADDR1: begin
          ack_vld_d = 1'b1;
          if (ten_hdr) begin
            if (hdr_hit) begin
              ack_d   = 1'b1;
              state_d = ST_ADDR2;
            end else begin
              state_d = ST_IDLE;
            end
          end else if (seven_hit) begin
            ack_d   = 1'b1;
            irq_set = 1'b1;
            state_d = ST_SLAVE;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_ADDR2: begin
          ack_vld_d = 1'b1;
          if (low_hit) begin
            ack_d   = 1'b1;
            irq_set = 1'b1;
            state_d = ST_SLAVE;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      ack_vld_q <= ack_vld_d;
      ack_q     <= ack_d;
    end
  end

  assign ack_vld    = ack_vld_q;
  assign ack        = ack_q;
  assign slave_mode = (state_q == ST_SLAVE);

  // R3: a decision only follows a byte that was not overridden by START
  p_ack_needs_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> ($past(rx_byte_vld) && !$past(rx_start)));
  // R6: every NACK leaves the block idle
  p_nack_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !ack) |-> (state_q == ST_IDLE));
  // R5: slave mode is only entered together with an ACK
  p_slave_entry_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_mode) |-> (ack_vld && ack));
  // R7: the second 10-bit stage is only reached through an ACKed header
  p_addr2_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ADDR2) && ($past(state_q) != ST_ADDR2)) |-> (ack_vld && ack));
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import i2c_addr_pkg::*;
#(
  parameter bit TEN_BIT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              rx_start,
  input  logic              rx_stop,
  input  logic              rx_byte_vld,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              ack_vld,
  output logic              ack,
  output logic              slave_mode,
  output logic              irq
);
  logic [1:0] rst_sync_q;
  logic rst_int_n;
  logic [BYTE_W-1:0] own_addr, ext_addr;
  logic srst, irq_set;
  logic ten_hdr, hdr_hit, seven_hit, low_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_addr_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .irq_set  (irq_set),
    .rdata    (reg_rdata),
    .own_addr (own_addr),
    .ext_addr (ext_addr),
    .irq      (irq),
    .srst     (srst)
  );

  i2c_addr_match #(.TEN_BIT_EN(TEN_BIT_EN)) u_match (
    .rx_byte   (rx_byte),
    .own_addr  (own_addr),
    .ext_addr  (ext_addr),
    .ten_hdr   (ten_hdr),
    .hdr_hit   (hdr_hit),
    .seven_hit (seven_hit),
    .low_hit   (low_hit)
  );

  i2c_addr_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .srst        (srst),
    .rx_start    (rx_start),
    .rx_stop     (rx_stop),
    .rx_byte_vld (rx_byte_vld),
    .ten_hdr     (ten_hdr),
    .hdr_hit     (hdr_hit),
    .seven_hit   (seven_hit),
    .low_hit     (low_hit),
    .ack_vld     (ack_vld),
    .ack         (ack),
    .slave_mode  (slave_mode),
    .irq_set     (irq_set)
  );

  // R2: the interrupt never rises outside slave mode
  p_irq_rise_slave_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq) |-> slave_mode);
  // R4: an ACK that does not enter slave mode never raises the interrupt
  p_first_quiet_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack_vld && ack && !slave_mode) |-> !$rose(irq));
  // R9: after a software reset the block is idle and the interrupt is clear
  p_srst_idle_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(reg_wr && (reg_addr == RA_SRST)) |-> (!slave_mode && !irq && !ack_vld));
  // R10: no decisions are produced while in slave mode
  p_slave_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(slave_mode) && slave_mode) |-> !ack_vld);
endmodule

// File: tb/i2c_addr_recog_bench.sv
module i2c_addr_recog_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       rx_start, rx_stop, rx_byte_vld;
  logic [7:0] rx_byte;
  logic       ack_vld, ack, slave_mode, irq;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_addr_recog u_i2c_addr_recog (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_start(rx_start),
    .rx_stop(rx_stop), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .ack_vld(ack_vld), .ack(ack), .slave_mode(slave_mode), .irq(irq)
  );

  // {req, kind, data, expected {ack_vld, ack, slave_mode, irq}}
  // kind: 0 START, 1 byte, 2 STOP, 3 wr own, 4 wr ext, 5 wr ctl, 6 wr srst
  localparam logic [19:0] VEC [30] = '{
    20'hB3A40, 20'hB43C0,                        // R11 own=A4h ext=3Ch
    20'h20000, 20'h21A5F,                        // R2 7-bit hit, R/W bit set
    20'h85002,                                   // R8 clear irq
    20'hA1772, 20'hA2000,                        // R10 byte in slave, STOP
    20'h31A40, 20'h30000, 20'h31A68, 20'h31A40,  // R3 no START, miss, after NACK
    20'h40000, 20'h41F4C,                        // R4 10-bit header hit
    20'h513CF,                                   // R5 second byte hit
    20'h85013,                                   // R8 ctl bit0=1 keeps irq
    20'hA0001,                                   // R10 START leaves slave
    20'h61F29, 20'h85000,                        // R6 header miss
    20'h60000, 20'h61F4C, 20'h613D8,             // R6 second byte miss
    20'h70000, 20'h71F5C, 20'h70000, 20'h71A4F,  // R7 restart then 7-bit
    20'h965A0,                                   // R9 srst
    20'h70000, 20'h71F4C, 20'h70000, 20'h713C8   // R7 ext byte as first byte
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    rx_start = 1'b0; rx_stop = 1'b0; rx_byte_vld = 1'b0; rx_byte = 8'h00;
  endtask

  task automatic step(input logic [3:0] kind, input logic [7:0] data);
    case (kind)
      4'd0: rx_start = 1'b1;
      4'd1: begin rx_byte_vld = 1'b1; rx_byte = data; end
      4'd2: rx_stop = 1'b1;
      4'd3: begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = data; end
      4'd4: begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = data; end
      4'd5: begin reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = data; end
      default: begin reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = data; end
    endcase
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic read_reg(input logic [1:0] a, input string req, input int exp);
    reg_addr = a;
    #1;
    check(req, $sformatf("reg %0d", a), reg_rdata, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    read_reg(2'd0, "R1", 0);
    read_reg(2'd1, "R1", 0);
    read_reg(2'd2, "R1", 0);
    check("R1", "outputs", {ack_vld, slave_mode, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 30; i++) begin
      logic [19:0] v;
      v = VEC[i];
      step(v[15:12], v[11:4]);
      check($sformatf("R%0d", v[19:16]), $sformatf("vec %0d", i),
            {ack_vld, ack, slave_mode, irq}, v[3:0]);
    end

    // R9: address registers retained after software reset
    read_reg(2'd0, "R9", 8'hA4);
    read_reg(2'd1, "R9", 8'h3C);
    // R11: control bits and write-only reset register readback
    step(4'd5, 8'h06);
    read_reg(2'd2, "R11", 8'h06);
    read_reg(2'd3, "R11", 8'h00);
    step(4'd6, 8'h00);
    read_reg(2'd2, "R9", 8'h00);
    // R11: START wins over a byte in the same cycle
    rx_start = 1'b1; rx_byte_vld = 1'b1; rx_byte = 8'hA4;
    @(posedge clk); @(negedge clk); idle_inputs();
    check("R11", "start+byte", {ack_vld, slave_mode}, 0);
    step(4'd1, 8'hA4);
    check("R11", "after start", {ack_vld, ack, slave_mode, irq}, 4'hF);
    // R1: hardware reset mid-run
    rst_n = 1'b0;
    #1;
    read_reg(2'd0, "R1", 0);
    read_reg(2'd1, "R1", 0);
    check("R1", "outputs hw", {ack_vld, slave_mode, irq}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule